// File: doc/BRIEF.md
# Two-Stage 32-bit Left Rotator

This block rotates a 32-bit word left by any amount from 0 to 31 and registers the result one clock after the operands arrive. The rotation is split in two. A fine stage moves bits by 0 to 7 places. It does this in four byte lanes, and each lane is a small multiply: a 16-bit value built from the lane's byte and the byte below it, multiplied by a one-hot power of two. A coarse stage then moves whole bytes, with one 4-to-1 byte multiplexer per output byte.

The word is handled as four bytes: byte 3 is bits [31:24] and byte 0 is bits [7:0]. The low three bits of the shift amount set the fine distance f. The high two bits set the coarse distance c in bytes. The total rotation is 8c + f. A caller presents data, amount and a valid strobe together, and reads the result with its valid flag one clock later.

Top module: `rot32_two_stage`

## Requirements
- R1: While rst_ni is low, res_o and valid_o are both zero.
- R2: valid_o equals the value valid_i had at the previous rising clock edge.
- R3: One clock after a cycle with valid_i high, res_o equals data_i rotated left by amt_i. Bits that leave bit 31 re-enter at bit 0.
- R4: With amt_i equal to 0, res_o equals data_i unchanged.
- R5: With amt_i[4:3] equal to 0, a rotation by 1 to 7 carries bits across byte boundaries, including from bit 31 into bit 0.
- R6: With amt_i[2:0] equal to 0, output byte i holds input byte (i - amt_i[4:3]) mod 4.
- R7: In a cycle with valid_i low, res_o keeps its previous value whatever data_i and amt_i carry.
- R8: The fine-amount decoder has exactly one of its eight code bits set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Word to rotate |
| amt_i | input | 5 | Left-rotate distance, binary |
| valid_i | input | 1 | Operands present this cycle |
| res_o | output | 32 | Registered rotated word |
| valid_o | output | 1 | res_o was loaded in the previous cycle |

## Verification
A single bit walked across every amount shows that the fine and coarse stages add to the correct total. It also shows that a bit crossing a byte boundary, or wrapping from bit 31 to bit 0, lands in one position only. Distinct byte patterns at whole-byte amounts separate the byte-reorder direction from its mirror image. Random words swept through all 32 amounts catch wrong neighbour wiring in any lane. Changing data_i and amt_i while valid_i is low shows that the result register holds its value.

// File: rtl/rot_pkg.sv
package rot_pkg;
  parameter int unsigned LANE_W  = 8;
  parameter int unsigned LANES   = 4;
  localparam int unsigned DATA_W  = LANE_W * LANES;
  localparam int unsigned FINE_W  = $clog2(LANE_W);
  localparam int unsigned COARSE_W = $clog2(LANES);
  localparam int unsigned SHIFT_W = FINE_W + COARSE_W;
endpackage

// File: rtl/rot_onehot_dec.sv
module rot_onehot_dec #(
  parameter int unsigned OUT_W = 8,
  localparam int unsigned IN_W = $clog2(OUT_W)
) (
  input  logic [IN_W-1:0]  amt_i,
  output logic [OUT_W-1:0] code_o
);
  assign code_o = OUT_W'(1) << amt_i;
endmodule

// File: rtl/rot_fine_lane.sv
module rot_fine_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] own_i,
  input  logic [LANE_W-1:0] lower_i,
  input  logic [LANE_W-1:0] code_i,
  output logic [LANE_W-1:0] lane_o
);
  // product upper half = own << f with the bits from lower filling in
  assign lane_o = LANE_W'(({own_i, lower_i} * {{LANE_W{1'b0}}, code_i}) >> LANE_W);
endmodule

// File: rtl/rot_byte_mux.sv
module rot_byte_mux #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned POS    = 0,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][LANE_W-1:0] lanes_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [LANE_W-1:0]            byte_o
);
  logic [SEL_W-1:0] src;
  assign src    = SEL_W'(POS) - sel_i;  // wraps mod LANES
  assign byte_o = lanes_i[src];
endmodule

// File: rtl/rot32_two_stage.sv
module rot32_two_stage
  import rot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SHIFT_W-1:0] amt_i,
  input  logic              valid_i,
  output logic [DATA_W-1:0] res_o,
  output logic              valid_o
);
  logic [LANE_W-1:0]             code;
  logic [LANES-1:0][LANE_W-1:0]  in_b;
  logic [LANES-1:0][LANE_W-1:0]  fine_b;
  logic [LANES-1:0][LANE_W-1:0]  out_b;
  logic [FINE_W-1:0]             fine_amt;
  logic [COARSE_W-1:0]           coarse_amt;

  assign in_b       = data_i;
  assign fine_amt   = amt_i[FINE_W-1:0];
  assign coarse_amt = amt_i[SHIFT_W-1:FINE_W];

  rot_onehot_dec #(.OUT_W(LANE_W)) u_dec (
    .amt_i (fine_amt),
    .code_o(code)
  );

  a_r8_onehot_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(code) == 1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rot_fine_lane #(.LANE_W(LANE_W)) u_fine (
      .own_i  (in_b[i]),
      .lower_i(in_b[(i + LANES - 1) % LANES]),
      .code_i (code),
      .lane_o (fine_b[i])
    );
    rot_byte_mux #(.LANE_W(LANE_W), .LANES(LANES), .POS(i)) u_mux (
      .lanes_i(fine_b),
      .sel_i  (coarse_amt),
      .byte_o (out_b[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= out_b;
    end
  end

  function automatic logic [DATA_W-1:0] rotl_ref(logic [DATA_W-1:0] d, logic [SHIFT_W-1:0] s);
    return (d << s) | (d >> (DATA_W - 32'(s)));
  endfunction

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_invalid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r3_rotate_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_o == rotl_ref($past(data_i), $past(amt_i)));
  a_r4_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amt_i == '0) |=> res_o == $past(data_i));
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
endmodule

// File: tb/rot32_two_stage_bench.sv
module rot32_two_stage_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [4:0]  amt_i = '0;
  logic        valid_i = 1'b0;
  logic [31:0] res_o;
  logic        valid_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rot32_two_stage u_rot32_two_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .amt_i(amt_i),
    .valid_i(valid_i), .res_o(res_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] model(logic [31:0] d, logic [4:0] s);
    logic [63:0] t;
    t = {d, d} << s;
    return t[63:32];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register)
  task automatic apply(logic [31:0] d, logic [4:0] s, logic v);
    @(negedge clk_i);
    data_i = d; amt_i = s; valid_i = v;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 res", res_o, 32'h0);
    check("R1 valid", {31'b0, valid_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero;
    apply(32'hA5C3_0F96, 5'd0, 1'b1);
    check("R4", res_o, 32'hA5C3_0F96);
    check("R2 valid high", {31'b0, valid_o}, 32'h1);
  endtask

  task automatic t_fine;
    apply(32'h8000_0001, 5'd1, 1'b1);
    check("R5 wrap 31->0", res_o, 32'h0000_0003);
    apply(32'h0000_0080, 5'd1, 1'b1);
    check("R5 cross byte", res_o, 32'h0000_0100);
    for (int s = 1; s < 8; s++) begin
      apply(32'hF000_00F0, 5'(s), 1'b1);
      check("R5 fine", res_o, model(32'hF000_00F0, 5'(s)));
    end
  endtask

  task automatic t_coarse;
    apply(32'h4433_2211, 5'd8, 1'b1);
    check("R6 c=1", res_o, 32'h3322_1144);
    apply(32'h4433_2211, 5'd16, 1'b1);
    check("R6 c=2", res_o, 32'h2211_4433);
    apply(32'h4433_2211, 5'd24, 1'b1);
    check("R6 c=3", res_o, 32'h1144_3322);
  endtask

  task automatic t_walk;
    for (int s = 0; s < 32; s++) begin
      apply(32'h0000_0001, 5'(s), 1'b1);
      check("R3 walk", res_o, 32'h1 << s);
    end
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] d;
      d = $urandom();
      for (int s = 0; s < 32; s++) begin
        apply(d, 5'(s), 1'b1);
        check("R3 sweep", res_o, model(d, 5'(s)));
      end
    end
  endtask

  task automatic t_hold;
    apply(32'h1234_5678, 5'd4, 1'b1);
    check("R3 load", res_o, 32'h2345_6781);
    apply(32'hFFFF_0000, 5'd13, 1'b0);
    check("R7 hold", res_o, 32'h2345_6781);
    check("R2 valid low", {31'b0, valid_o}, 32'h0);
    apply(32'h0BAD_F00D, 5'd31, 1'b0);
    check("R7 hold2", res_o, 32'h2345_6781);
    apply(32'h0000_0002, 5'd31, 1'b1);
    check("R3 wrap", res_o, 32'h0000_0001);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_fine();
    t_coarse();
    t_walk();
    t_sweep();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule